// File: doc/BRIEF.md
# Line Fill and Flush Buffer

This block sits between the data cache array and the cache-side bus interface. When the cache misses, the block takes the miss (line address plus the offset of the word the load wants) and gathers the eight words of that line as they return from the bus. The bus returns the wanted word first, then the following words in ascending order, wrapping back to the start of the aligned line. Each word is stored in the slot given by its true offset in the line. The wanted word is also passed straight to the load-result port in the cycle it arrives.

The cache array is not written until the whole line has arrived. The block then writes the line into the array over three cycles. Each cycle carries a word-enable mask that covers one third of the line. No new miss is taken from the moment a miss is accepted until the last of those three cycles.

On the eviction side, the cache hands over a dirty line as two half-line beats. The block assembles each line into a two-entry queue and presents the queued lines, oldest first, as write-line requests toward the bus. Tag lookup, replacement and the bus protocol are handled elsewhere.

Top module: `line_xfer_buffer`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `fill_we`, `load_valid` and `wl_valid` are low and `flush_ready` is high.
- R2: `miss_accept` is high in a cycle with `miss_req` high and `busy` low. From the next cycle, `busy` stays high until the last fill-write cycle and drops in the cycle after it.
- R3: After a miss at offset `off`, the k-th accepted read beat (k = 0..7) is word `(off+k) mod 8` of the line. Word i occupies bits `[32*i+31 : 32*i]` of `fill_data`.
- R4: `fill_we` rises only in the cycle after the eighth beat. It stays high for exactly three consecutive cycles, with `fill_mask` equal to 8'h07, then 8'h38, then 8'hC0. `fill_line_addr` is the address of the miss during all three cycles.
- R5: `load_valid` is high exactly in the cycle the first beat of a line arrives, with `load_data` equal to that beat's `rd_data`. It is low in every other cycle.
- R6: A read beat that arrives while no line is being collected is ignored. It raises neither `load_valid` nor `fill_we`, and it leaves `busy` low.
- R7: A `miss_req` raised while `busy` is high is not accepted. The line address of the fill in progress is unchanged.
- R8: An eviction takes two cycles with `ev_valid` high. The first beat gives the low half (bits 127:0) of the line and the line address. The second beat gives the high half, and the address input is not used. The entry can be seen on `wl_valid` from the cycle after the second beat.
- R9: At most two lines are queued. `flush_ready` is low while two complete lines are queued and high otherwise. An `ev_valid` offered while `flush_ready` is low is not taken.
- R10: Queued lines leave in the order they were evicted. While `wl_valid` is high and `wl_ack` is low, `wl_line_addr` and `wl_data` hold. An entry leaves on `wl_valid && wl_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_req | input | 1 | Cache miss wants a line fill |
| miss_line_addr | input | 27 | Aligned line address of the miss |
| miss_word | input | 3 | Offset of the word the load wants |
| miss_accept | output | 1 | Miss taken this cycle |
| busy | output | 1 | Fill in progress (collecting or writing) |
| rd_valid | input | 1 | Read data beat from bus |
| rd_data | input | 32 | Read data word |
| load_valid | output | 1 | Forwarded load word valid |
| load_data | output | 32 | Forwarded load word |
| fill_we | output | 1 | Cache array write enable |
| fill_mask | output | 8 | Word enables for this fill cycle |
| fill_line_addr | output | 27 | Line address being written |
| fill_data | output | 256 | Assembled line, word i in bits 32i+31:32i |
| ev_valid | input | 1 | Eviction beat valid |
| ev_line_addr | input | 27 | Evicted line address (first beat) |
| ev_data | input | 128 | Half line, low half first |
| flush_ready | output | 1 | Eviction beat can be taken |
| wl_valid | output | 1 | Write-line request pending |
| wl_line_addr | output | 27 | Address of oldest queued line |
| wl_data | output | 256 | Data of oldest queued line |
| wl_ack | input | 1 | Bus takes the oldest queued line |

## Verification
The bench targets every starting offset, including 7, which wraps after the first word. A design that places words by arrival order instead of true offset, or that gets the wrap wrong, writes a rotated line into the array. Random idle gaps between beats are mixed with miss requests. A fill that starts early, runs longer or shorter than three cycles, or lets a second miss through would show a wrong mask sequence or a changed line address. On the flush side, the bench fills the queue, offers an extra eviction while the queue is full, and then drains it. A queue that took the stalled line, used the second beat's address, or returned entries out of order gives a mismatch on the write-line port.

// File: rtl/lxb_pkg.sv
package lxb_pkg;

  typedef enum logic {
    COL_IDLE = 1'b0,
    COL_RUN  = 1'b1
  } col_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/lxb_fill_collect.sv
module lxb_fill_collect import lxb_pkg::*; #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int LADDR_W    = 27,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_BITS = WORD_W * LINE_WORDS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LADDR_W-1:0]   start_addr,
  input  logic [OFF_W-1:0]     start_off,
  input  logic                 rd_valid,
  input  logic [WORD_W-1:0]    rd_data,
  output logic                 collecting,
  output logic                 line_done,
  output logic [LADDR_W-1:0]   line_addr,
  output logic [LINE_BITS-1:0] line_data,
  output logic                 fwd_valid,
  output logic [WORD_W-1:0]    fwd_data
);

  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  col_state_e         state_q, state_d;
  logic [OFF_W-1:0]   beat_q, beat_d;
  logic [OFF_W-1:0]   off_q;
  logic [LADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]   slot;
  logic               take;

  assign take      = (state_q == COL_RUN) && rd_valid;
  assign slot      = off_q + beat_q;          // wraps inside the aligned line
  assign line_done = take && (beat_q == LAST_BEAT);
  assign fwd_valid = take && (beat_q == '0);
  assign fwd_data  = rd_data;
  assign collecting = (state_q == COL_RUN);
  assign line_addr  = addr_q;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    case (state_q)
      COL_IDLE: if (start) begin
        state_d = COL_RUN;
        beat_d  = '0;
      end
      COL_RUN: if (take) begin
        beat_d = beat_q + 1'b1;
        if (line_done) state_d = COL_IDLE;
      end
      default: state_d = COL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= COL_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start && (state_q == COL_IDLE)) begin
      addr_q <= start_addr;
      off_q  <= start_off;
    end
  end

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (take && (slot == OFF_W'(i))) word_q <= rd_data;
    end
    assign line_data[i*WORD_W +: WORD_W] = word_q;
  end

  // Forwarded word only comes while a line is being gathered
  assert_fwd_in_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> $past(state_q == COL_RUN));

endmodule

// File: rtl/lxb_fill_seq.sv
module lxb_fill_seq import lxb_pkg::*; #(
  parameter int LINE_WORDS = 8,
  parameter int FILL_STEPS = 3,
  localparam int STEP_W    = (FILL_STEPS > 1) ? $clog2(FILL_STEPS) : 1,
  localparam int WPS       = ceil_div(LINE_WORDS, FILL_STEPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  active,
  output logic [LINE_WORDS-1:0] mask
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FILL_STEPS - 1);

  logic              active_q, active_d;
  logic [STEP_W-1:0] step_q, step_d;

  always_comb begin
    active_d = active_q;
    step_d   = step_q;
    if (start) begin
      active_d = 1'b1;
      step_d   = '0;
    end else if (active_q) begin
      if (step_q == LAST_STEP) active_d = 1'b0;
      else                     step_d   = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else begin
      active_q <= active_d;
      step_q   <= step_d;
    end
  end

  assign active = active_q;

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_mask
    assign mask[i] = active_q && (step_q == STEP_W'(i / WPS));
  end

  assert_fill_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && step_q == LAST_STEP && !start) |=> !active_q);

endmodule

// File: rtl/lxb_flush_queue.sv
module lxb_flush_queue #(
  parameter int LADDR_W     = 27,
  parameter int LINE_BITS   = 256,
  parameter int DEPTH       = 2,
  parameter int BEATS       = 2,
  localparam int BEAT_W     = LINE_BITS / BEATS,
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int BC_W       = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  input  logic [LADDR_W-1:0]   ev_line_addr,
  input  logic [BEAT_W-1:0]    ev_data,
  output logic                 ev_ready,
  output logic                 wl_valid,
  output logic [LADDR_W-1:0]   wl_line_addr,
  output logic [LINE_BITS-1:0] wl_data,
  input  logic                 wl_ack
);

  localparam logic [BC_W-1:0]  LAST_BC = BC_W'(BEATS - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic                 asm_q, asm_d;
  logic [BC_W-1:0]      bc_q, bc_d;
  logic [PTR_W-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [LADDR_W-1:0]   addr_mem [DEPTH];
  logic [LINE_BITS-1:0] data_mem [DEPTH];
  logic                 acc, push, pop;

  assign ev_ready = asm_q || (cnt_q != CNT_W'(DEPTH));
  assign acc      = ev_valid && ev_ready;
  assign push     = acc && (bc_q == LAST_BC);
  assign wl_valid = (cnt_q != '0);
  assign pop      = wl_valid && wl_ack;
  assign wl_line_addr = addr_mem[rptr_q];
  assign wl_data      = data_mem[rptr_q];

  always_comb begin
    asm_d  = asm_q;
    bc_d   = bc_q;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (acc) begin
      if (push) begin
        asm_d  = 1'b0;
        bc_d   = '0;
        wptr_d = (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
      end else begin
        asm_d  = 1'b1;
        bc_d   = bc_q + 1'b1;
      end
    end
    if (pop) rptr_d = (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q  <= 1'b0;
      bc_q   <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      asm_q  <= asm_d;
      bc_q   <= bc_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      data_mem[wptr_q][bc_q*BEAT_W +: BEAT_W] <= ev_data;
      if (bc_q == '0) addr_mem[wptr_q] <= ev_line_addr;
    end
  end

  assert_queue_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_valid && !wl_ack) |=> (wl_valid && $stable(wl_line_addr) && $stable(wl_data)));

endmodule

// File: rtl/line_xfer_buffer.sv
module line_xfer_buffer import lxb_pkg::*; #(
  parameter int WORD_W      = 32,
  parameter int LINE_WORDS  = 8,
  parameter int LADDR_W     = 27,
  parameter int FILL_STEPS  = 3,
  parameter int FLUSH_DEPTH = 2,
  parameter int FLUSH_BEATS = 2,
  localparam int OFF_W      = $clog2(LINE_WORDS),
  localparam int LINE_BITS  = WORD_W * LINE_WORDS,
  localparam int BEAT_W     = LINE_BITS / FLUSH_BEATS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  miss_req,
  input  logic [LADDR_W-1:0]    miss_line_addr,
  input  logic [OFF_W-1:0]      miss_word,
  output logic                  miss_accept,
  output logic                  busy,
  input  logic                  rd_valid,
  input  logic [WORD_W-1:0]     rd_data,
  output logic                  load_valid,
  output logic [WORD_W-1:0]     load_data,
  output logic                  fill_we,
  output logic [LINE_WORDS-1:0] fill_mask,
  output logic [LADDR_W-1:0]    fill_line_addr,
  output logic [LINE_BITS-1:0]  fill_data,
  input  logic                  ev_valid,
  input  logic [LADDR_W-1:0]    ev_line_addr,
  input  logic [BEAT_W-1:0]     ev_data,
  output logic                  flush_ready,
  output logic                  wl_valid,
  output logic [LADDR_W-1:0]    wl_line_addr,
  output logic [LINE_BITS-1:0]  wl_data,
  input  logic                  wl_ack
);

  logic collecting, line_done, fill_active;

  assign busy        = collecting || fill_active;
  assign miss_accept = miss_req && !busy;
  assign fill_we     = fill_active;

  lxb_fill_collect #(
    .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LADDR_W(LADDR_W)
  ) u_collect (
    .clk(clk), .rst_n(rst_n),
    .start(miss_accept), .start_addr(miss_line_addr), .start_off(miss_word),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .collecting(collecting), .line_done(line_done),
    .line_addr(fill_line_addr), .line_data(fill_data),
    .fwd_valid(load_valid), .fwd_data(load_data)
  );

  lxb_fill_seq #(
    .LINE_WORDS(LINE_WORDS), .FILL_STEPS(FILL_STEPS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(line_done),
    .active(fill_active), .mask(fill_mask)
  );

  lxb_flush_queue #(
    .LADDR_W(LADDR_W), .LINE_BITS(LINE_BITS),
    .DEPTH(FLUSH_DEPTH), .BEATS(FLUSH_BEATS)
  ) u_flush (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_line_addr(ev_line_addr), .ev_data(ev_data),
    .ev_ready(flush_ready),
    .wl_valid(wl_valid), .wl_line_addr(wl_line_addr), .wl_data(wl_data),
    .wl_ack(wl_ack)
  );

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_accept |=> busy);

  assert_fill_after_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_we) |-> ($past(line_done) && !collecting));

  assert_no_write_while_gather_R3: assert property (@(posedge clk) disable iff (!rst_n)
    collecting |-> !fill_we);

endmodule

// File: tb/line_xfer_buffer_tb.sv
module line_xfer_buffer_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         miss_req;
  logic [26:0]  miss_line_addr;
  logic [2:0]   miss_word;
  logic         miss_accept, busy;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         load_valid;
  logic [31:0]  load_data;
  logic         fill_we;
  logic [7:0]   fill_mask;
  logic [26:0]  fill_line_addr;
  logic [255:0] fill_data;
  logic         ev_valid;
  logic [26:0]  ev_line_addr;
  logic [127:0] ev_data;
  logic         flush_ready, wl_valid;
  logic [26:0]  wl_line_addr;
  logic [255:0] wl_data;
  logic         wl_ack;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [26:0]  mq_addr [4];
  logic [255:0] mq_data [4];
  int mq_head = 0;
  int mq_cnt  = 0;

  always #10 clk = ~clk;

  line_xfer_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .miss_req(miss_req), .miss_line_addr(miss_line_addr), .miss_word(miss_word),
    .miss_accept(miss_accept), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .load_valid(load_valid), .load_data(load_data),
    .fill_we(fill_we), .fill_mask(fill_mask), .fill_line_addr(fill_line_addr),
    .fill_data(fill_data),
    .ev_valid(ev_valid), .ev_line_addr(ev_line_addr), .ev_data(ev_data),
    .flush_ready(flush_ready),
    .wl_valid(wl_valid), .wl_line_addr(wl_line_addr), .wl_data(wl_data),
    .wl_ack(wl_ack)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask(input int s);
    case (s)
      0:       return 8'h07;
      1:       return 8'h38;
      default: return 8'hC0;
    endcase
  endfunction

  // Starts and ends at a falling edge + 5
  task automatic run_fill(input logic [26:0] la, input logic [2:0] off, input bit gaps);
    logic [255:0] exp;
    logic [31:0]  d;
    exp = '0;
    @(negedge clk);
    miss_req = 1'b1; miss_line_addr = la; miss_word = off;
    #5 chk(miss_accept == 1'b1, "R2 accept", 256'(miss_accept), 256'd1);
    @(negedge clk);
    miss_req = 1'b0;
    #5 chk(busy == 1'b1, "R2 busy after accept", 256'(busy), 256'd1);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      if (gaps) begin
        while ($urandom_range(0, 2) == 0) begin
          rd_valid = 1'b0; miss_req = 1'b1; miss_line_addr = 27'($urandom);
          #5;
          chk(miss_accept == 1'b0, "R7 miss while busy", 256'(miss_accept), 256'd0);
          chk(load_valid == 1'b0, "R5 no forward in gap", 256'(load_valid), 256'd0);
          @(negedge clk);
          miss_req = 1'b0;
        end
      end
      d = $urandom;
      rd_valid = 1'b1; rd_data = d;
      exp[((int'(off) + k) % 8) * 32 +: 32] = d;
      #5;
      chk(load_valid == (k == 0), "R5 forward strobe", 256'(load_valid), 256'(k == 0));
      if (k == 0) chk(load_data == d, "R5 forward data", 256'(load_data), 256'(d));
      chk(fill_we == 1'b0, "R4 no early write", 256'(fill_we), 256'd0);
      @(negedge clk);
    end
    rd_valid = 1'b0;
    for (int s = 0; s < 3; s++) begin
      #5;
      chk(fill_we == 1'b1, "R4 write cycle", 256'(fill_we), 256'd1);
      chk(fill_mask == exp_mask(s), "R4 mask", 256'(fill_mask), 256'(exp_mask(s)));
      chk(fill_line_addr == la, "R7 fill address", 256'(fill_line_addr), 256'(la));
      chk(fill_data == exp, "R3 word placement", fill_data, exp);
      chk(busy == 1'b1, "R2 busy in write", 256'(busy), 256'd1);
      @(negedge clk);
    end
    #5;
    chk(fill_we == 1'b0, "R4 write ends", 256'(fill_we), 256'd0);
    chk(busy == 1'b0, "R2 busy drops", 256'(busy), 256'd0);
  endtask

  // Starts at a falling edge; two beats of one eviction
  task automatic evict(input logic [26:0] la, input logic [255:0] line);
    ev_valid = 1'b1; ev_line_addr = la; ev_data = line[127:0];
    #5 chk(flush_ready == 1'b1, "R9 ready beat0", 256'(flush_ready), 256'd1);
    @(negedge clk);
    ev_line_addr = 27'($urandom); ev_data = line[255:128];
    #5 chk(flush_ready == 1'b1, "R8 ready beat1", 256'(flush_ready), 256'd1);
    @(negedge clk);
    ev_valid = 1'b0;
    mq_addr[(mq_head + mq_cnt) % 4] = la;
    mq_data[(mq_head + mq_cnt) % 4] = line;
    mq_cnt++;
    #5;
    chk(wl_valid == 1'b1, "R8 entry visible", 256'(wl_valid), 256'd1);
    chk(flush_ready == (mq_cnt < 2), "R9 ready level", 256'(flush_ready), 256'(mq_cnt < 2));
    @(negedge clk);
  endtask

  // Starts at a falling edge; takes the head entry
  task automatic drain_one();
    wl_ack = 1'b1;
    #5;
    chk(wl_valid == 1'b1, "R10 valid", 256'(wl_valid), 256'd1);
    chk(wl_line_addr == mq_addr[mq_head], "R8 R10 head address",
        256'(wl_line_addr), 256'(mq_addr[mq_head]));
    chk(wl_data == mq_data[mq_head], "R8 R10 head data", wl_data, mq_data[mq_head]);
    @(negedge clk);
    wl_ack = 1'b0;
    mq_head = (mq_head + 1) % 4;
    mq_cnt--;
    #5 chk(wl_valid == (mq_cnt != 0), "R10 valid after pop", 256'(wl_valid), 256'(mq_cnt != 0));
    @(negedge clk);
  endtask

  function automatic logic [255:0] rnd_line();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] l0, l1;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; miss_req = 1'b0; miss_line_addr = '0; miss_word = '0;
    rd_valid = 1'b0; rd_data = '0; ev_valid = 1'b0; ev_line_addr = '0;
    ev_data = '0; wl_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && fill_we == 1'b0 && load_valid == 1'b0, "R1 reset fill side",
        256'({busy, fill_we, load_valid}), 256'd0);
    chk(wl_valid == 1'b0 && flush_ready == 1'b1, "R1 reset flush side",
        256'({wl_valid, flush_ready}), 256'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #5 chk(busy == 1'b0 && wl_valid == 1'b0 && flush_ready == 1'b1, "R1 after release",
           256'({busy, wl_valid, flush_ready}), 256'd1);

    // Stray beat while idle
    @(negedge clk);
    rd_valid = 1'b1; rd_data = 32'hDEAD_BEEF;
    #5 chk(load_valid == 1'b0, "R6 stray beat no forward", 256'(load_valid), 256'd0);
    @(negedge clk);
    rd_valid = 1'b0;
    #5 chk(fill_we == 1'b0 && busy == 1'b0, "R6 stray beat no fill",
           256'({fill_we, busy}), 256'd0);

    // Directed offsets, including the ones at both ends of the line
    run_fill(27'h123_4567, 3'd0, 1'b0);
    run_fill(27'h000_0ABC, 3'd7, 1'b0);
    run_fill(27'h7FF_FFFF, 3'd3, 1'b1);
    // Random fills with gaps
    for (int n = 0; n < 12; n++) run_fill(27'($urandom), 3'($urandom), 1'b1);

    // Flush queue: fill, stall, drain
    @(negedge clk);
    l0 = rnd_line(); l1 = rnd_line();
    evict(27'h0AA_0001, l0);
    evict(27'h055_0002, l1);
    ev_valid = 1'b1; ev_line_addr = 27'h1; ev_data = '1;
    #5 chk(flush_ready == 1'b0, "R9 full stalls", 256'(flush_ready), 256'd0);
    @(negedge clk);
    ev_valid = 1'b0;
    #5 chk(flush_ready == 1'b0, "R9 stalled beat not taken", 256'(flush_ready), 256'd0);
    @(negedge clk);
    drain_one();
    chk(flush_ready == 1'b1, "R9 ready after drain", 256'(flush_ready), 256'd1);
    drain_one();

    // Random mix of evictions and drains
    for (int n = 0; n < 60; n++) begin
      if (mq_cnt < 2 && ($urandom_range(0, 1) == 0 || mq_cnt == 0))
        evict(27'($urandom), rnd_line());
      else
        drain_one();
    end
    while (mq_cnt > 0) drain_one();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule